// File: doc/BRIEF.md
# SPI Controller with Break-Protected Status Flags

This block is a byte-wide SPI controller that works as either master or slave. The CPU reaches it through three small registers: control, status and data. It raises an interrupt when a byte has arrived or when an overrun has occurred. The serial side has separate pins for clock out and clock in, select out and select in, and serial data out and data in. In master mode the block drives the clock and the select. In slave mode it samples the external clock through a two-stage synchroniser.

The core of the design is how the status flags behave around system power and debug states. While the debugger holds a break, CPU accesses normally cannot disturb any flag. The clearing sequence is read status with the flag set, then access the data register. If the first step of that sequence was done before the break, the block remembers it until after the break. A clear-enable input lets software clear flags during a break when it wants to. In wait mode the shifter keeps running but the CPU is locked out. In stop mode the whole block freezes. A reset applied in stop aborts any transfer.

Top module: `spi_brkflag_ctrl`

## Requirements
- R1: After reset the registers hold these values: control (address 0) reads 0x00, status (address 1) reads 0x02, `irq` is 0, `ss_o_n` is 1 and `sclk_o` is 0. Data is at address 2. Control bits: [0] enable, [1] master, [2] clock idle level, [3] clock phase, [5:4] rate, [6] receive interrupt enable, [7] error interrupt enable. Status bits: [0] receive full, [1] transmit empty, [2] overrun, [3] busy.
- R2: In master mode a write to the data register while transmit empty is 1 starts a full-duplex transfer of 8 bits, most significant bit first. The transfer works for every idle-level/phase pair. With phase 0 the input is sampled on the clock edge that leaves the idle level. With phase 1 it is sampled on the edge that returns to it. The received byte is readable at address 2 and receive full is set.
- R3: In master mode each half period of `sclk_o` lasts 2^rate system clock cycles.
- R4: In master mode `ss_o_n` is low for the whole transfer and high again once the transfer ends.
- R5: If a byte completes while receive full is still 1, overrun is set and the earlier byte stays in the data register.
- R6: A flag is cleared by two steps: a status read that finds the flag set, then a read of the data register. A data read with no such status read clears nothing.
- R7: While `dbg_break`=1 and `dbg_clr_en`=0, status and data accesses leave every flag unchanged. A data write leaves transmit empty at 1 and starts no transfer.
- R8: A status read done before a protected break stays in effect through the break. The first data read after the break then clears the flag.
- R9: While `dbg_break`=1 and `dbg_clr_en`=1, the normal two-step sequence clears flags. A flag cleared this way stays cleared after the break ends.
- R10: While `mode_wait`=1, reads return 0 and writes are ignored, but a transfer in progress completes and sets its flags.
- R11: While `mode_stop`=1, the serial clock, the edge count and all register contents hold still and reads return 0. The transfer resumes and completes correctly once stop is released.
- R12: A reset applied during stop aborts the transfer in progress and returns every register to its reset value.
- R13: In slave mode, with `ss_i_n` low, the block shifts its loaded byte out on `sdo`, most significant bit first, using the edges of `sclk_i`. It stores the byte received on `sdi` and sets receive full.
- R14: `irq` is 1 exactly when (receive interrupt enable and receive full) or (error interrupt enable and overrun), and this also holds in wait mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reads have side effects) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid while `reg_rd` is high |
| irq | output | 1 | Interrupt request |
| mode_wait | input | 1 | Wait mode: CPU access blocked, shifter runs |
| mode_stop | input | 1 | Stop mode: block frozen |
| dbg_break | input | 1 | Debug break active |
| dbg_clr_en | input | 1 | Allow flag clearing during a break |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ss_o_n | output | 1 | Select driven in master mode, active low |
| ss_i_n | input | 1 | Select received in slave mode, active low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with the default DW of 8, so each transfer covers 16 clock edges and the edge counter wraps on its own. Every value of the two-bit rate field is used, so half periods of 1, 2, 4 and 8 cycles are measured. All four idle-level/phase combinations are exercised against a behavioural peer. The byte width keeps transfers short enough that overrun, break, wait and stop sequences can each be played through several complete bytes.

// File: rtl/spi_brkflag_ctrl.sv
`timescale 1ns/1ps
module spi_brkflag_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          mode_wait,
  input  logic          mode_stop,
  input  logic          dbg_break,
  input  logic          dbg_clr_en,
  output logic          sclk_o,
  input  logic          sclk_i,
  output logic          ss_o_n,
  input  logic          ss_i_n,
  output logic          sdo,
  input  logic          sdi
);
  localparam int CW = $clog2(2*DW);
  localparam int PW = 3;
  localparam logic [CW-1:0] LAST = CW'(2*DW-1);

  logic [7:0]    ctrl;
  logic          txe, rxf, ovr, rx_arm, ovr_arm, act, cap, obit, sck_d;
  logic [DW-1:0] txbuf, shreg, rxbuf, shnx;
  logic [CW-1:0] edg;
  logic [PW-1:0] presc;
  logic [1:0]    sck_sy, ss_sy;

  logic en, mstr, cpol, cpha, rie, eie;
  logic [1:0] rate;
  assign en   = ctrl[0];
  assign mstr = ctrl[1];
  assign cpol = ctrl[2];
  assign cpha = ctrl[3];
  assign rate = ctrl[5:4];
  assign rie  = ctrl[6];
  assign eie  = ctrl[7];

  logic acc, prot, wr_ctl, wr_dat, rd_st, rd_dat;
  assign acc    = ~mode_wait & ~mode_stop;
  assign prot   = dbg_break & ~dbg_clr_en;
  assign wr_ctl = acc & reg_wr & (reg_addr == 2'd0);
  assign wr_dat = acc & reg_wr & (reg_addr == 2'd2);
  assign rd_st  = acc & reg_rd & (reg_addr == 2'd1);
  assign rd_dat = acc & reg_rd & (reg_addr == 2'd2);

  logic sck_s, ss_s, tick, ev, lead, done, load, sin, busy;
  logic rx_clr, ovr_clr, ovr_set;
  assign sck_s = sck_sy[1];
  assign ss_s  = ss_sy[1];
  assign tick  = presc == PW'((4'd1 << rate) - 4'd1);
  assign ev    = en & ~mode_stop & (mstr ? (act & tick) : (~ss_s & (sck_s ^ sck_d)));
  assign lead  = mstr ? ~edg[0] : (sck_s ^ cpol);
  assign done  = ev & (edg == LAST);
  assign sin   = cpha ? sdi : cap;
  assign shnx  = {shreg[DW-2:0], sin};
  assign load  = en & ~txe & (mstr ? ~act : ss_s);
  assign busy  = mstr ? act : (en & ~ss_s);

  assign rx_clr  = rd_dat & rx_arm & ~prot;
  assign ovr_clr = rd_dat & ovr_arm & ~prot;
  assign ovr_set = done & rxf & ~rx_clr;

  // serial engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= '1;
      sck_d  <= 1'b0;
      act    <= 1'b0;
      edg    <= '0;
      presc  <= '0;
      shreg  <= '0;
      cap    <= 1'b0;
      obit   <= 1'b0;
    end else if (!mode_stop) begin
      sck_sy <= {sck_sy[0], sclk_i};
      ss_sy  <= {ss_sy[0], ss_i_n};
      sck_d  <= sck_s;
      if (!en) begin
        act   <= 1'b0;
        edg   <= '0;
        presc <= '0;
      end else if (load) begin
        shreg <= txbuf;
        act   <= mstr;
        edg   <= '0;
        presc <= '0;
      end else if (!mstr && ss_s) begin
        edg <= '0;
      end else begin
        if (mstr) presc <= (act && !tick) ? presc + PW'(1) : '0;
        if (ev) begin
          edg <= done ? '0 : edg + CW'(1);
          if (lead) begin
            if (cpha) obit <= shreg[DW-1];
            else      cap  <= sdi;
          end else begin
            shreg <= shnx;
          end
          if (done) act <= 1'b0;
        end
      end
    end
  end

  // registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      txbuf   <= '0;
      rxbuf   <= '0;
      txe     <= 1'b1;
      rxf     <= 1'b0;
      ovr     <= 1'b0;
      rx_arm  <= 1'b0;
      ovr_arm <= 1'b0;
    end else if (!mode_stop) begin
      if (wr_ctl) ctrl <= reg_wdata[7:0];

      if (load) txe <= 1'b1;
      else if (wr_dat && txe && !prot) begin
        txe   <= 1'b0;
        txbuf <= reg_wdata;
      end

      if (rd_st && !prot) rx_arm <= rxf;
      else if (rx_clr)    rx_arm <= 1'b0;
      if (rd_st && !prot) ovr_arm <= ovr;
      else if (ovr_clr)   ovr_arm <= 1'b0;

      if (done && (!rxf || rx_clr)) begin
        rxf   <= 1'b1;
        rxbuf <= shnx;
      end else if (rx_clr) begin
        rxf <= 1'b0;
      end

      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (acc && reg_rd) begin
      case (reg_addr)
        2'd0:    reg_rdata = DW'(ctrl);
        2'd1:    reg_rdata = DW'({busy, ovr, txe, rxf});
        2'd2:    reg_rdata = rxbuf;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq    = (rie & rxf) | (eie & ovr);
  assign sclk_o = cpol ^ (mstr & edg[0]);
  assign ss_o_n = ~(mstr & act);
  assign sdo    = cpha ? obit : shreg[DW-1];

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mstr && !act && !txe && !mode_stop) |=> (act && txe));

  p_ssn_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_o_n) |-> $past(!txe));

  p_ovr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> (ovr && rxf && $stable(rxbuf)));

  p_prot_rxf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && rxf) |=> rxf);

  p_prot_txe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && txe) |=> txe);

  p_wait_noacc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wait && reg_wr && reg_addr == 2'd0) |=> $stable(ctrl));

  p_freeze_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stop |=> ($stable(edg) && $stable(shreg) && $stable(sclk_o)));
endmodule

// File: tb/spi_brkflag_ctrl_tb.sv
`timescale 1ns/1ps
module spi_brkflag_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, sclk_o, ss_o_n, sdo;
  logic mode_wait = 0, mode_stop = 0, dbg_break = 0, dbg_clr_en = 0;
  logic sclk_i = 0, ss_i_n = 1, sdi = 0;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  spi_brkflag_ctrl #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mode_wait(mode_wait), .mode_stop(mode_stop), .dbg_break(dbg_break), .dbg_clr_en(dbg_clr_en),
    .sclk_o(sclk_o), .sclk_i(sclk_i), .ss_o_n(ss_o_n), .ss_i_n(ss_i_n), .sdo(sdo), .sdi(sdi));

  // peer model for master transfers
  logic mon = 0, m_cpol = 0, m_cpha = 0, ss_first = 1;
  logic [7:0] s_tx = '0, mcap = '0;
  int bp = 0, nedge = 0;
  time t0 = 0, t1 = 0;

  always @(sclk_o) if (mon) begin
    #1;
    nedge++;
    if (nedge == 1) begin t0 = $time; ss_first = ss_o_n; end
    if (nedge == 2) t1 = $time;
    if ((sclk_o != m_cpol) ^ m_cpha) mcap = {mcap[6:0], sdo};
    else if (bp >= 0) begin sdi = s_tx[bp]; bp--; end
  end

  // {cpol, cpha, rate[1:0], tx[7:0], peer byte[7:0]}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 2'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 2'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 2'd3, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 2'd3, 8'h96, 8'h69},
    {1'b1, 1'b1, 2'd0, 8'hE7, 8'h18},
    {1'b0, 1'b1, 2'd2, 8'h01, 8'h80},
    {1'b1, 1'b0, 2'd1, 8'hFE, 8'h7F}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic arm_peer(input logic [7:0] c, input logic [7:0] peer);
    m_cpol = c[2]; m_cpha = c[3]; s_tx = peer; mcap = '0; nedge = 0;
    if (!c[3]) begin sdi = peer[7]; bp = 6; end
    else bp = 7;
  endtask

  task automatic mxfer(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] peer);
    mon = 0;
    wr(2'd0, c);
    arm_peer(c, peer);
    mon = 1;
    wr(2'd2, tx);
    wait (ss_o_n == 1'b0);
    wait (ss_o_n == 1'b1);
    repeat (2) @(negedge clk);
    mon = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d, c, sc, scap;
    int ne;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 ss_o_n", ss_o_n, 1);
    chk("R1 sclk_o", sclk_o, 0);
    rd(2'd0, d); chk("R1 control", d, 8'h00);
    rd(2'd1, d); chk("R1 status", d, 8'h02);

    // R2 R3 R4 vector table
    for (int i = 0; i < 8; i++) begin
      c = {2'b00, VEC[i][17:16], VEC[i][18], VEC[i][19], 2'b11};
      mxfer(c, VEC[i][15:8], VEC[i][7:0]);
      chk("R2 mosi byte", mcap, VEC[i][15:8]);
      chk("R2 sclk idle", sclk_o, VEC[i][19]);
      chk("R3 half period", 32'(t1 - t0), 32'(4 << VEC[i][17:16]));
      chk("R4 select low", ss_first, 0);
      chk("R4 select high", ss_o_n, 1);
      rd(2'd1, d); chk("R2 status", d, 8'h03);
      rd(2'd2, d); chk("R2 rx byte", d, VEC[i][7:0]);
      rd(2'd1, d); chk("R6 cleared", d, 8'h02);
    end

    // R6 data read alone does not clear
    mxfer(8'h03, 8'h12, 8'h34);
    rd(2'd2, d); chk("R6 data", d, 8'h34);
    rd(2'd1, d); chk("R6 no clear", d, 8'h03);
    rd(2'd2, d);
    rd(2'd1, d); chk("R6 two-step", d, 8'h02);

    // R5 R14 overflow
    mxfer(8'h83, 8'h11, 8'hA1);
    chk("R14 no irq rxf", irq, 0);
    mxfer(8'h83, 8'h22, 8'hB2);
    chk("R14 irq ovr", irq, 1);
    rd(2'd1, d); chk("R5 status", d, 8'h07);
    rd(2'd2, d); chk("R5 old byte kept", d, 8'hA1);
    rd(2'd1, d); chk("R5 cleared", d, 8'h02);
    chk("R14 irq low", irq, 0);

    // R7 protected break
    mxfer(8'h03, 8'h5C, 8'hC5);
    dbg_break = 1; dbg_clr_en = 0;
    rd(2'd1, d); chk("R7 status", d, 8'h03);
    rd(2'd2, d); chk("R7 data", d, 8'hC5);
    rd(2'd1, d); chk("R7 no clear", d, 8'h03);
    nedge = 0; mon = 1;
    wr(2'd2, 8'h55);
    repeat (40) @(negedge clk);
    chk("R7 no edges", nedge, 0);
    chk("R7 no select", ss_o_n, 1);
    mon = 0;
    rd(2'd1, d); chk("R7 txe kept", d, 8'h03);

    // R8 first step survives break
    dbg_break = 0;
    rd(2'd1, d);
    dbg_break = 1;
    rd(2'd2, d);
    rd(2'd1, d); chk("R8 held in break", d, 8'h03);
    dbg_break = 0;
    rd(2'd2, d);
    rd(2'd1, d); chk("R8 cleared after", d, 8'h02);

    // R9 clear enabled during break
    mxfer(8'h03, 8'h66, 8'h6B);
    dbg_break = 1; dbg_clr_en = 1;
    rd(2'd1, d); rd(2'd2, d);
    rd(2'd1, d); chk("R9 cleared in break", d, 8'h02);
    dbg_break = 0; dbg_clr_en = 0;
    rd(2'd1, d); chk("R9 stays clear", d, 8'h02);

    // R10 R14 wait mode
    mon = 0;
    wr(2'd0, 8'h73);
    arm_peer(8'h73, 8'h4B);
    mon = 1;
    wr(2'd2, 8'hB4);
    mode_wait = 1;
    wait (irq == 1'b1);
    @(negedge clk);
    chk("R14 irq in wait", irq, 1);
    rd(2'd1, d); chk("R10 read blocked", d, 8'h00);
    wr(2'd2, 8'h77);
    mode_wait = 0;
    rd(2'd1, d); chk("R10 status after", d, 8'h03);
    repeat (40) @(negedge clk);
    chk("R10 write ignored", ss_o_n, 1);
    mon = 0;
    chk("R10 mosi byte", mcap, 8'hB4);
    rd(2'd2, d); chk("R10 rx byte", d, 8'h4B);
    rd(2'd1, d); chk("R10 cleared", d, 8'h02);

    // R11 stop freezes and resumes
    wr(2'd0, 8'h23);
    arm_peer(8'h23, 8'h39);
    mon = 1;
    wr(2'd2, 8'hC6);
    wait (ss_o_n == 1'b0);
    repeat (20) @(negedge clk);
    mode_stop = 1;
    @(negedge clk);
    sc = {7'd0, sclk_o}; ne = nedge;
    repeat (30) @(negedge clk);
    chk("R11 sclk frozen", sclk_o, sc);
    chk("R11 edges frozen", nedge, ne);
    chk("R11 select held", ss_o_n, 0);
    rd(2'd1, d); chk("R11 read blocked", d, 8'h00);
    mode_stop = 0;
    wait (ss_o_n == 1'b1);
    repeat (2) @(negedge clk);
    mon = 0;
    chk("R11 mosi byte", mcap, 8'hC6);
    rd(2'd1, d); chk("R11 status", d, 8'h03);
    rd(2'd2, d); chk("R11 rx byte", d, 8'h39);

    // R12 reset during stop
    wr(2'd0, 8'h37);
    wr(2'd2, 8'h99);
    wait (ss_o_n == 1'b0);
    repeat (10) @(negedge clk);
    mode_stop = 1;
    repeat (3) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mode_stop = 0;
    @(negedge clk);
    chk("R12 select", ss_o_n, 1);
    chk("R12 sclk", sclk_o, 0);
    rd(2'd0, d); chk("R12 control", d, 8'h00);
    rd(2'd1, d); chk("R12 status", d, 8'h02);
    repeat (60) @(negedge clk);
    chk("R12 aborted", ss_o_n, 1);

    // R13 slave transfer
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hA5);
    repeat (4) @(negedge clk);
    sdi = 1'b0; scap = '0;
    ss_i_n = 0;
    repeat (8) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      sdi = 8'h5E >> b;
      repeat (8) @(negedge clk);
      scap = {scap[6:0], sdo};
      sclk_i = 1;
      repeat (8) @(negedge clk);
      sclk_i = 0;
    end
    repeat (8) @(negedge clk);
    ss_i_n = 1;
    repeat (4) @(negedge clk);
    chk("R13 sdo byte", scap, 8'hA5);
    rd(2'd1, d); chk("R13 status", d, 8'h03);
    rd(2'd2, d); chk("R13 rx byte", d, 8'h5E);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule